// File: doc/BRIEF.md
# Conflict-Free 3D Neighbourhood Memory

This block holds a three-dimensional grid of samples and returns a whole cubic window of them in one access. With the default window side of four, a single request brings back the 64 samples of the 4x4x4 window whose lowest corner is the requested base coordinate. A side of two gives the 2x2x2 window used for linear interpolation. Requests may come in any order, and the block accepts one on every clock with no stall.

The grid is spread over side-cubed independent banks. A sample at (x, y, z) lives in the bank chosen by the low bits of each coordinate. Its address inside that bank is built from the high bits. Because any window covers every residue class exactly once on each axis, a window touches each bank exactly once, so the simultaneous reads never collide. Address logic works out, for each bank, which block row that bank must read for the current base. A rotation network driven by the base residues then puts the bank outputs back in window order.

A write port loads or updates single samples. A window that would extend past the far edge of the grid is not wrapped. Such a request is answered with an error flag and an all-zero payload.

Top module: `nbr_mem`

## Requirements
- R1: With side K=4, response element n = dx + 4*dy + 16*dz, carried in rs_data bits [n*DW +: DW], equals the sample stored at (bx+dx, by+dy, bz+dz) for the request base (bx, by, bz), with dx, dy and dz each in 0..3.
- R2: A request is accepted on every clock cycle in which rq_valid is high, back to back and for any base order, and each one gets its own correct response.
- R3: rs_valid is high exactly two clock edges after the edge that samples a request, and low in every other cycle.
- R4: A request with bx > GX-K, by > GY-K or bz > GZ-K gets rs_valid=1, rs_err=1 and an all-zero rs_data. Any other request gets rs_err=0.
- R5: A clock edge with wr_en high stores wr_data at (wr_x, wr_y, wr_z), and later windows that cover that point return the new value.
- R6: A request sampled on the same edge as a write to a point inside its window returns that point's previous value.
- R7: With side K=2, response element n = dx + 2*dy + 4*dz holds the sample at (bx+dx, by+dy, bz+dz), with dx, dy and dz each in 0..1.
- R8: While reset is high, and on the first edge after it, rs_valid and rs_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the response pipeline |
| wr_en | input | 1 | Write one grid sample on this edge |
| wr_x | input | $clog2(GX) | Write coordinate, x axis |
| wr_y | input | $clog2(GY) | Write coordinate, y axis |
| wr_z | input | $clog2(GZ) | Write coordinate, z axis |
| wr_data | input | DW | Sample value to store |
| rq_valid | input | 1 | A window request is present |
| rq_x | input | $clog2(GX) | Window base, x axis |
| rq_y | input | $clog2(GY) | Window base, y axis |
| rq_z | input | $clog2(GZ) | Window base, z axis |
| rs_valid | output | 1 | Response present, two edges after the request |
| rs_err | output | 1 | The requested window would pass the grid edge |
| rs_data | output | K*K*K*DW | Window samples in (dx, dy, dz) order, dx fastest |

## Verification
The bench builds two copies of the block. One has side 4 on an 8x8x8 grid, which gives 64 banks of eight words. The other has side 2 on a 4x4x4 grid. Both grids are small enough to load every point with a distinct value and then request every possible base, back to back with idle gaps. This covers every combination of base residues that drives the rotation network and every edge-error position on each axis. Directed writes then test overwriting a sample and a write made on the same edge as a read of that point.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  // Number of cells in a cubic window of the given side.
  function automatic int cube(input int side);
    return side * side * side;
  endfunction

  // Bits needed to hold a residue modulo side (side is a power of two >= 2).
  function automatic int res_bits(input int side);
    return (side > 1) ? $clog2(side) : 1;
  endfunction

endpackage

// File: rtl/nbr_axis_gen.sv
// Per-axis address generation: for every residue class r, selects the block
// row that the bank holding residue r must read so that the window starting
// at base covers it. Also flags a window that would pass the grid edge.
module nbr_axis_gen #(
  parameter int K    = 4,
  parameter int GRID = 16,
  parameter int CW   = $clog2(GRID),
  parameter int RW   = nbr_pkg::res_bits(K),
  parameter int BW   = CW - RW
) (
  input  logic [CW-1:0]        base,
  output logic [K-1:0][BW-1:0] blk,
  output logic                 oob
);

  logic [RW-1:0] base_res;
  logic [BW-1:0] base_blk;

  assign base_res = base[RW-1:0];
  assign base_blk = base[CW-1:RW];

  // A residue below the base residue has already been passed in the base
  // block row, so the window reaches it in the next row up.
  for (genvar r = 0; r < K; r++) begin : g_res
    logic carry;
    assign carry  = (RW'(r) < base_res);
    assign blk[r] = base_blk + BW'(carry);
  end

  assign oob = (int'(base) + K - 1) >= GRID;

endmodule

// File: rtl/nbr_bank.sv
// One bank: simple dual-port memory with a registered, read-first output,
// in the form block RAM inference expects.
module nbr_bank #(
  parameter int DW    = 16,
  parameter int AW    = 6,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/nbr_reorder.sv
// Rotation network: moves bank outputs, indexed by coordinate residue, into
// window order. One rotation per axis, each a K-way select per cell.
module nbr_reorder #(
  parameter int DW = 16,
  parameter int K  = 4,
  parameter int NC = nbr_pkg::cube(K),
  parameter int RW = nbr_pkg::res_bits(K)
) (
  input  logic [NC-1:0][DW-1:0] bank_q,
  input  logic [RW-1:0]         sx,
  input  logic [RW-1:0]         sy,
  input  logic [RW-1:0]         sz,
  output logic [NC-1:0][DW-1:0] win
);

  logic [NC-1:0][DW-1:0] rot_x;
  logic [NC-1:0][DW-1:0] rot_y;

  // Cell index is {z, y, x} with RW bits per axis, since K is a power of two.
  for (genvar k = 0; k < K; k++) begin : g_z
    for (genvar j = 0; j < K; j++) begin : g_y
      for (genvar i = 0; i < K; i++) begin : g_x
        localparam int CELL = i + K * j + K * K * k;
        logic [RW-1:0]   ix, iy, iz;
        logic [3*RW-1:0] src_x, src_y, src_z;

        assign ix    = RW'(i) + sx;
        assign iy    = RW'(j) + sy;
        assign iz    = RW'(k) + sz;
        assign src_x = {RW'(k), RW'(j), ix};
        assign src_y = {RW'(k), iy, RW'(i)};
        assign src_z = {iz, RW'(j), RW'(i)};

        assign rot_x[CELL] = bank_q[src_x];
        assign rot_y[CELL] = rot_x[src_y];
        assign win[CELL]   = rot_y[src_z];
      end
    end
  end

endmodule

// File: rtl/nbr_mem.sv
// Conflict-free cubic neighbourhood memory. Two-cycle read pipeline:
// edge 1 reads the banks, edge 2 registers the reordered window.
module nbr_mem #(
  parameter int DW = 16,
  parameter int GX = 16,
  parameter int GY = 16,
  parameter int GZ = 16,
  parameter int K  = 4,
  localparam int CXW = $clog2(GX),
  localparam int CYW = $clog2(GY),
  localparam int CZW = $clog2(GZ),
  localparam int NC  = nbr_pkg::cube(K)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CXW-1:0]     wr_x,
  input  logic [CYW-1:0]     wr_y,
  input  logic [CZW-1:0]     wr_z,
  input  logic [DW-1:0]      wr_data,
  input  logic               rq_valid,
  input  logic [CXW-1:0]     rq_x,
  input  logic [CYW-1:0]     rq_y,
  input  logic [CZW-1:0]     rq_z,
  output logic               rs_valid,
  output logic               rs_err,
  output logic [NC*DW-1:0]   rs_data
);

  localparam int RW  = nbr_pkg::res_bits(K);
  localparam int BXW = CXW - RW;
  localparam int BYW = CYW - RW;
  localparam int BZW = CZW - RW;
  localparam int AW  = BXW + BYW + BZW;

  // Per-axis block-row selection.
  logic [K-1:0][BXW-1:0] xb;
  logic [K-1:0][BYW-1:0] yb;
  logic [K-1:0][BZW-1:0] zb;
  logic                  oob_x, oob_y, oob_z;

  nbr_axis_gen #(.K(K), .GRID(GX)) u_ax (.base(rq_x), .blk(xb), .oob(oob_x));
  nbr_axis_gen #(.K(K), .GRID(GY)) u_ay (.base(rq_y), .blk(yb), .oob(oob_y));
  nbr_axis_gen #(.K(K), .GRID(GZ)) u_az (.base(rq_z), .blk(zb), .oob(oob_z));

  // Write address is shared by all banks; the residues pick the bank.
  logic [AW-1:0] waddr;
  assign waddr = {wr_z[CZW-1:RW], wr_y[CYW-1:RW], wr_x[CXW-1:RW]};

  logic [NC-1:0][DW-1:0] bank_q;

  for (genvar gz = 0; gz < K; gz++) begin : g_bz
    for (genvar gy = 0; gy < K; gy++) begin : g_by
      for (genvar gx = 0; gx < K; gx++) begin : g_bx
        localparam int BANK = gx + K * gy + K * K * gz;
        logic          we;
        logic [AW-1:0] raddr;

        assign we    = wr_en && (wr_x[RW-1:0] == RW'(gx))
                             && (wr_y[RW-1:0] == RW'(gy))
                             && (wr_z[RW-1:0] == RW'(gz));
        assign raddr = {zb[gz], yb[gy], xb[gx]};

        nbr_bank #(.DW(DW), .AW(AW)) u_bank (
          .clk  (clk),
          .we   (we),
          .waddr(waddr),
          .wdata(wr_data),
          .raddr(raddr),
          .rdata(bank_q[BANK])
        );
      end
    end
  end

  // Stage 1: control aligned with the bank read.
  logic          s1_valid;
  logic          s1_err;
  logic [RW-1:0] s1_sx, s1_sy, s1_sz;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
    end else begin
      s1_valid <= rq_valid;
      s1_err   <= rq_valid && (oob_x || oob_y || oob_z);
    end
    s1_sx <= rq_x[RW-1:0];
    s1_sy <= rq_y[RW-1:0];
    s1_sz <= rq_z[RW-1:0];
  end

  logic [NC-1:0][DW-1:0] win;

  nbr_reorder #(.DW(DW), .K(K)) u_rot (
    .bank_q(bank_q),
    .sx    (s1_sx),
    .sy    (s1_sy),
    .sz    (s1_sz),
    .win   (win)
  );

  // Stage 2: registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_err   <= 1'b0;
    end else begin
      rs_valid <= s1_valid;
      rs_err   <= s1_valid && s1_err;
    end
    rs_data <= s1_err ? '0 : win;
  end

endmodule

// File: rtl/nbr_mem_chk.sv
module nbr_mem_chk #(
  parameter int DW = 16,
  parameter int GX = 16,
  parameter int GY = 16,
  parameter int GZ = 16,
  parameter int K  = 4,
  localparam int CXW = $clog2(GX),
  localparam int CYW = $clog2(GY),
  localparam int CZW = $clog2(GZ),
  localparam int NC  = nbr_pkg::cube(K)
) (
  input logic             clk,
  input logic             rst,
  input logic             rq_valid,
  input logic [CXW-1:0]   rq_x,
  input logic [CYW-1:0]   rq_y,
  input logic [CZW-1:0]   rq_z,
  input logic             rs_valid,
  input logic             rs_err,
  input logic [NC*DW-1:0] rs_data
);

  logic [1:0] since_rst;
  logic       edge_req;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign edge_req = rq_valid && ((int'(rq_x) > GX - K) || (int'(rq_y) > GY - K)
                                 || (int'(rq_z) > GZ - K));

  // R3
  rs_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (rs_valid == $past(rq_valid, 2)));

  // R4
  edge_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (rs_err == $past(edge_req, 2)));

  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rs_err |-> (rs_data == '0));

  // R4
  err_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rs_err |-> rs_valid);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rs_valid && !rs_err));

endmodule

bind nbr_mem nbr_mem_chk #(.DW(DW), .GX(GX), .GY(GY), .GZ(GZ), .K(K)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rq_valid(rq_valid),
  .rq_x    (rq_x),
  .rq_y    (rq_y),
  .rq_z    (rq_z),
  .rs_valid(rs_valid),
  .rs_err  (rs_err),
  .rs_data (rs_data)
);

// File: tb/nbr_env.sv
// One configuration under test: loads every grid point, sweeps every base,
// then checks overwrite and same-edge write/read.
module nbr_env #(
  parameter int K  = 4,
  parameter int G  = 8,
  parameter int DW = 12
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   checks,
  output int   fails
);

  localparam int CW = $clog2(G);
  localparam int NC = K * K * K;

  logic             wr_en, rq_valid;
  logic [CW-1:0]    wr_x, wr_y, wr_z, rq_x, rq_y, rq_z;
  logic [DW-1:0]    wr_data;
  logic             rs_valid, rs_err;
  logic [NC*DW-1:0] rs_data;

  nbr_mem #(.DW(DW), .GX(G), .GY(G), .GZ(G), .K(K)) u0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z), .wr_data(wr_data),
    .rq_valid(rq_valid), .rq_x(rq_x), .rq_y(rq_y), .rq_z(rq_z),
    .rs_valid(rs_valid), .rs_err(rs_err), .rs_data(rs_data)
  );

  logic [DW-1:0] model [G][G][G];

  // Requests in flight: slot 1 driven one negedge ago, slot 2 two ago.
  bit               p1v, p2v, p1e, p2e;
  logic [NC*DW-1:0] p1d, p2d;
  string            p1t, p2t, tag;

  function automatic logic [DW-1:0] pat(input int x, input int y, input int z);
    return DW'((x + G * y + G * G * z) ^ 'h5A3);
  endfunction

  function automatic logic [NC*DW-1:0] expv(input int bx, input int by, input int bz);
    logic [NC*DW-1:0] v = '0;
    for (int dz = 0; dz < K; dz++)
      for (int dy = 0; dy < K; dy++)
        for (int dx = 0; dx < K; dx++)
          v[(dx + K * dy + K * K * dz) * DW +: DW] = model[bx + dx][by + dy][bz + dz];
    return v;
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL K=%0d %s", K, msg);
    end
  endtask

  task automatic cycle(input bit rv, input int x, input int y, input int z,
                       input bit wv, input int wx, input int wy, input int wz,
                       input logic [DW-1:0] wd);
    bit err;
    @(negedge clk);
    // R3: valid appears exactly two edges after the request
    chk(rs_valid == p2v, $sformatf("R3 rs_valid act=%0b exp=%0b", rs_valid, p2v));
    if (p2v) begin
      chk(rs_err == p2e, $sformatf("R4 rs_err act=%0b exp=%0b", rs_err, p2e));
      chk(rs_data == p2d, $sformatf("%s rs_data act=%h exp=%h", p2t, rs_data, p2d));
    end
    p2v = p1v; p2e = p1e; p2d = p1d; p2t = p1t;
    err = (x > G - K) || (y > G - K) || (z > G - K);
    p1v = rv;
    p1e = err;
    p1d = (rv && !err) ? expv(x, y, z) : '0;
    p1t = err ? "R4" : tag;
    rq_valid = rv;
    rq_x = CW'(x); rq_y = CW'(y); rq_z = CW'(z);
    wr_en = wv;
    wr_x = CW'(wx); wr_y = CW'(wy); wr_z = CW'(wz);
    wr_data = wd;
    if (wv) model[wx][wy][wz] = wd;
  endtask

  initial begin
    int slot;
    done = 1'b0; checks = 0; fails = 0;
    wr_en = 1'b0; rq_valid = 1'b0;
    wr_x = '0; wr_y = '0; wr_z = '0; wr_data = '0;
    rq_x = '0; rq_y = '0; rq_z = '0;
    p1v = 0; p2v = 0; p1e = 0; p2e = 0; p1d = '0; p2d = '0;
    p1t = ""; p2t = ""; tag = "";
    wait (rst == 1'b0);
    @(negedge clk);
    // R8: pipeline quiet out of reset
    chk(!rs_valid && !rs_err, $sformatf("R8 reset act=%0b%0b exp=00", rs_valid, rs_err));

    // Load every point (R5 covered by the sweep reading them back)
    for (int z = 0; z < G; z++)
      for (int y = 0; y < G; y++)
        for (int x = 0; x < G; x++)
          cycle(0, 0, 0, 0, 1, x, y, z, pat(x, y, z));

    // Sweep every base back to back, with an idle slot every seventh request
    tag = (K == 2) ? "R7 R2 R5" : "R1 R2 R5";
    slot = 0;
    for (int z = 0; z < G; z++)
      for (int y = 0; y < G; y++)
        for (int x = 0; x < G; x++) begin
          cycle(1, x, y, z, 0, 0, 0, 0, '0);
          slot++;
          if (slot % 7 == 0) cycle(0, 0, 0, 0, 0, 0, 0, 0, '0);
        end
    cycle(0, 0, 0, 0, 0, 0, 0, 0, '0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, '0);

    // R5: overwrite one point, then read a window that covers it
    tag = "R5";
    cycle(0, 0, 0, 0, 1, 1, 1, 1, DW'('hABC));
    cycle(1, 0, 0, 0, 0, 0, 0, 0, '0);
    cycle(1, 1, 1, 1, 0, 0, 0, 0, '0);

    // R6: write on the same edge as a read of that point gives the old value
    tag = "R6";
    cycle(1, 0, 0, 0, 1, 1, 1, 1, DW'('h123));
    cycle(1, 0, 0, 0, 0, 0, 0, 0, '0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, '0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, '0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, '0);
    done = 1'b1;
  end

endmodule

// File: tb/sim_nbr_mem.sv
`timescale 1ns/1ps
module sim_nbr_mem;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic d0, d1;
  int   c0, c1, f0, f1;

  always #2 clk = ~clk;

  nbr_env #(.K(4), .G(8), .DW(12)) env_k4 (
    .clk(clk), .rst(rst), .done(d0), .checks(c0), .fails(f0));

  nbr_env #(.K(2), .G(4), .DW(12)) env_k2 (
    .clk(clk), .rst(rst), .done(d1), .checks(c1), .fails(f1));

  initial begin
    rst = 1'b1;
    repeat (4) @(posedge clk);
    rst <= 1'b0;
  end

  initial begin
    int wd;
    int wd_fail;
    wd = 0;
    wd_fail = 0;
    @(posedge clk);
    while (!(d0 && d1) && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!(d0 && d1)) begin
      wd_fail = 1;
      $display("FAIL watchdog expired act=running exp=done");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", c0 + c1 + wd_fail, f0 + f1 + wd_fail);
    $finish;
  end

endmodule